// File: doc/BRIEF.md
# Three-Bank Cascaded Interrupt Controller

This block gathers interrupt requests from three banks of level-sensitive sources and presents a single interrupt request to a processor. The first bank, called the local bank, has eight sources of its own. The two wide banks have thirty-two sources each. Every source has an enable bit. A source counts as pending while its input is high and its enable bit is set.

Software services an interrupt by reading one status word first. This primary word carries the eight local pending bits and two summary bits, one per wide bank. It also carries a set of fast-path bits that copy eleven chosen wide-bank sources directly, so the handler can reach them without a second read. A source that has a fast-path bit does not raise its bank's summary bit. The summary bits have no mask of their own. Masks are changed through write-one-to-set and write-one-to-clear registers on a plain 32-bit register port. Writes land on the clock edge and reads are combinational.

The request output is registered. It follows the OR of the primary status word one cycle later.

Top module: `tbic_top`

## Requirements
- R1: After reset every enable bit is 0, every pending word reads 0 and `irq_out` is 0, whatever the source levels.
- R2: A write to an enable offset (local 0x18, wide bank A 0x10, wide bank B 0x14) sets each enable bit whose data bit is 1. Data bits that are 0 change nothing. A read of either the enable offset or the disable offset of a bank returns that bank's mask, zero-extended to 32 bits.
- R3: A write to a disable offset (local 0x24, wide bank A 0x1C, wide bank B 0x20) clears each enable bit whose data bit is 1.
- R4: Pending words read at 0x04 (bank A) and 0x08 (bank B) equal source level AND enable. Bits 7:0 of the primary word at 0x00 are the same for the local bank.
- R5: Bit 8 (bank A) and bit 9 (bank B) of the primary word are set when at least one enabled non-fast-path source of that bank is high. These bits have no mask of their own.
- R6: Primary bits 10 to 14 copy the pending state of bank A sources 7, 9, 10, 18 and 19, in that order. Bits 15 to 20 copy bank B sources 21, 22, 23, 24, 25 and 30, in that order. A fast-path source never sets bit 8 or bit 9.
- R7: Writes to the local enable and disable offsets affect only mask bits 7:0. They never change a wide-bank mask, so fast-path sources are masked only through their own bank.
- R8: `irq_out` equals the OR of the primary word as it was in the previous clock cycle.
- R9: Any offset outside the nine mapped ones reads 0, and writes to it change no mask. Primary bits 31:21 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_loc | input | 8 | Local bank source levels |
| src_a | input | 32 | Wide bank A source levels |
| src_b | input | 32 | Wide bank B source levels |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The assertions check mask behaviour on every cycle:
- set and clear writes take effect on the next cycle;
- local-bank writes leave the wide masks untouched;
- the request rises only after a cycle with an enabled high source, and drops once none remains;
- the summary bits ignore fast-path sources;
- unmapped offsets read zero.

The exact bit position of each fast-path source, and the ordering of the fields in the primary word, can be shown only by the bench's scenarios. The same holds for the zero-extension of the local mask and the one-cycle lag of the request. The bench drives chosen source and mask patterns and compares whole read words against values worked out from the requirements.

// File: rtl/tbic_pkg.sv
package tbic_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int LOC_W    = 8;
    localparam int WIDE_W   = 32;
    localparam int FPA_N    = 5;
    localparam int FPB_N    = 6;
    localparam int SUM_A    = LOC_W;
    localparam int SUM_B    = LOC_W + 1;
    localparam int FPA_LSB  = LOC_W + 2;
    localparam int FPB_LSB  = FPA_LSB + FPA_N;
    localparam int USED_W   = FPB_LSB + FPB_N;
    localparam int PAD_W    = DATA_W - USED_W;

    localparam logic [ADDR_W-1:0] OFF_PEND_L = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_PEND_A = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_PEND_B = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_SET_A  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_SET_B  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_SET_L  = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_CLR_A  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_CLR_B  = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_CLR_L  = 8'h24;

    // Source index tapped by fast-path slot i of a wide bank (bank 0 = A, 1 = B).
    function automatic int fast_src(input int bank, input int i);
        int r;
        r = 0;
        if (bank == 0) begin
            case (i)
                0: r = 7;
                1: r = 9;
                2: r = 10;
                3: r = 18;
                default: r = 19;
            endcase
        end else begin
            r = (i < 5) ? 21 + i : 30;
        end
        return r;
    endfunction

    function automatic logic [WIDE_W-1:0] fast_mask(input int bank);
        logic [WIDE_W-1:0] m;
        int n;
        m = '0;
        n = (bank == 0) ? FPA_N : FPB_N;
        for (int i = 0; i < n; i++) m[fast_src(bank, i)] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/tbic_mask_reg.sv
module tbic_mask_reg
    import tbic_pkg::*;
#(
    parameter int W = 8,
    parameter logic [ADDR_W-1:0] SET_OFF = 8'h18,
    parameter logic [ADDR_W-1:0] CLR_OFF = 8'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [W-1:0]      mask_q
);
    logic hit_set, hit_clr;

    always_comb begin
        hit_set = wr && (addr == SET_OFF);
        hit_clr = wr && (addr == CLR_OFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (hit_set) begin
            mask_q <= mask_q | wdata[W-1:0];
        end else if (hit_clr) begin
            mask_q <= mask_q & ~wdata[W-1:0];
        end
    end
endmodule

// File: rtl/tbic_fast_tap.sv
module tbic_fast_tap
    import tbic_pkg::*;
#(
    parameter int BANK = 0,
    parameter int N    = 5
) (
    input  logic [WIDE_W-1:0] pend,
    output logic [N-1:0]      fast,
    output logic              summary
);
    localparam logic [WIDE_W-1:0] FMASK = fast_mask(BANK);

    for (genvar i = 0; i < N; i++) begin : g_tap
        assign fast[i] = pend[fast_src(BANK, i)];
    end

    assign summary = |(pend & ~FMASK);
endmodule

// File: rtl/tbic_read_mux.sv
module tbic_read_mux
    import tbic_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] prim,
    input  logic [WIDE_W-1:0] pend_a,
    input  logic [WIDE_W-1:0] pend_b,
    input  logic [LOC_W-1:0]  mask_l,
    input  logic [WIDE_W-1:0] mask_a,
    input  logic [WIDE_W-1:0] mask_b,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        unique case (addr)
            OFF_PEND_L:            rdata = prim;
            OFF_PEND_A:            rdata = pend_a;
            OFF_PEND_B:            rdata = pend_b;
            OFF_SET_L, OFF_CLR_L:  rdata = {{(DATA_W-LOC_W){1'b0}}, mask_l};
            OFF_SET_A, OFF_CLR_A:  rdata = mask_a;
            OFF_SET_B, OFF_CLR_B:  rdata = mask_b;
            default:               rdata = '0;
        endcase
    end
endmodule

// File: rtl/tbic_top.sv
module tbic_top
    import tbic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        src_loc,
    input  logic [31:0]       src_a,
    input  logic [31:0]       src_b,
    input  logic [7:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_out
);
    logic [LOC_W-1:0]  mask_l;
    logic [WIDE_W-1:0] mask_a, mask_b;
    logic [LOC_W-1:0]  pend_l;
    logic [WIDE_W-1:0] pend_a, pend_b;
    logic [FPA_N-1:0]  fast_a;
    logic [FPB_N-1:0]  fast_b;
    logic              sum_a, sum_b;
    logic [DATA_W-1:0] prim;
    logic              irq_q;

    tbic_mask_reg #(.W(LOC_W), .SET_OFF(OFF_SET_L), .CLR_OFF(OFF_CLR_L)) u_mask_l (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .mask_q(mask_l));
    tbic_mask_reg #(.W(WIDE_W), .SET_OFF(OFF_SET_A), .CLR_OFF(OFF_CLR_A)) u_mask_a (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .mask_q(mask_a));
    tbic_mask_reg #(.W(WIDE_W), .SET_OFF(OFF_SET_B), .CLR_OFF(OFF_CLR_B)) u_mask_b (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .mask_q(mask_b));

    always_comb begin
        pend_l = src_loc & mask_l;
        pend_a = src_a & mask_a;
        pend_b = src_b & mask_b;
    end

    tbic_fast_tap #(.BANK(0), .N(FPA_N)) u_tap_a (
        .pend(pend_a), .fast(fast_a), .summary(sum_a));
    tbic_fast_tap #(.BANK(1), .N(FPB_N)) u_tap_b (
        .pend(pend_b), .fast(fast_b), .summary(sum_b));

    assign prim = {{PAD_W{1'b0}}, fast_b, fast_a, sum_b, sum_a, pend_l};

    tbic_read_mux u_rd (
        .addr(reg_addr), .prim(prim), .pend_a(pend_a), .pend_b(pend_b),
        .mask_l(mask_l), .mask_a(mask_a), .mask_b(mask_b), .rdata(reg_rdata));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |prim;
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/tbic_checker.sv
module tbic_checker
    import tbic_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        src_loc,
    input logic [31:0]       src_a,
    input logic [31:0]       src_b,
    input logic [7:0]        reg_addr,
    input logic              reg_wr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              irq_out,
    input logic [LOC_W-1:0]  mask_l,
    input logic [WIDE_W-1:0] mask_a,
    input logic [WIDE_W-1:0] mask_b
);
    localparam logic [WIDE_W-1:0] FMA = fast_mask(0);
    logic any_live, mapped;

    always_comb begin
        any_live = (|(src_loc & mask_l)) || (|(src_a & mask_a)) || (|(src_b & mask_b));
        mapped   = reg_addr inside {OFF_PEND_L, OFF_PEND_A, OFF_PEND_B, OFF_SET_A,
                   OFF_SET_B, OFF_SET_L, OFF_CLR_A, OFF_CLR_B, OFF_CLR_L};
    end

    a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_SET_A) |=> ((mask_a & $past(reg_wdata)) == $past(reg_wdata)));
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_CLR_B) |=> ((mask_b & $past(reg_wdata)) == '0));
    a_r7_local_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == OFF_SET_L || reg_addr == OFF_CLR_L)) |=> ($stable(mask_a) && $stable(mask_b)));
    a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(any_live));
    a_r8_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !any_live |=> !irq_out);
    a_r5_summary_skips_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_PEND_L && (src_a & mask_a & ~FMA) == '0) |-> !reg_rdata[SUM_A]);
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (reg_rdata == '0));
endmodule

bind tbic_top tbic_checker u_chk (
    .clk(clk), .rst_n(rst_n), .src_loc(src_loc), .src_a(src_a), .src_b(src_b),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out),
    .mask_l(mask_l), .mask_a(mask_a), .mask_b(mask_b));

// File: tb/sim_tbic_top.sv
`timescale 1ns/1ps
module sim_tbic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_loc = '0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tbic_top u0 (.clk(clk), .rst_n(rst_n), .src_loc(src_loc), .src_a(src_a), .src_b(src_b),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out));

    // {write offset (FF = none), write data, read offset, expected read}
    localparam int NV = 14;
    localparam logic [79:0] VEC [NV] = '{
        {8'h10, 32'h0000_0080, 8'h00, 32'h0000_0400},  // R6 fast path only, no bit 8
        {8'h10, 32'h0000_0001, 8'h00, 32'h0000_0500},  // R5 summary A
        {8'hFF, 32'h0,         8'h04, 32'h0000_0081},  // R4 bank A pending
        {8'h14, 32'h4000_0000, 8'h00, 32'h0010_0500},  // R6 source B30 -> bit 20
        {8'h18, 32'h0000_FF03, 8'h18, 32'h0000_0003},  // R7 upper local bits dropped
        {8'hFF, 32'h0,         8'h00, 32'h0010_0503},  // R4 local pending
        {8'h1C, 32'h0000_0080, 8'h10, 32'h0000_0001},  // R3 clear A7
        {8'hFF, 32'h0,         8'h00, 32'h0010_0103},  // R3 fast bit gone
        {8'h14, 32'h0FE0_0000, 8'h00, 32'h001F_8303},  // R6 B21-25, R5 summary B
        {8'h1C, 32'h0000_0000, 8'h00, 32'h001F_8303},  // R2 zero write no effect
        {8'h20, 32'h0C00_0000, 8'h00, 32'h001F_8103},  // R3 clear B26,B27
        {8'h24, 32'h0000_0003, 8'h20, 32'h43E0_0000},  // R2 read via disable offset
        {8'h30, 32'hFFFF_FFFF, 8'h14, 32'h43E0_0000},  // R9 unmapped write ignored
        {8'h10, 32'h000C_0600, 8'h00, 32'h001F_F900}   // R6 A9,A10,A18,A19
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        src_loc = 8'hFF; src_a = '1; src_b = '1;
        #1;
        chk("R1 irq in reset", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd("R1 primary after reset", 8'h00, 32'h0);
        rd("R1 mask A after reset", 8'h10, 32'h0);
        chk("R1 irq after reset", {31'b0, irq_out}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][79:72] != 8'hFF) wr(VEC[i][79:72], VEC[i][71:40]);
            rd($sformatf("row %0d", i), VEC[i][39:32], VEC[i][31:0]);
        end

        rd("R9 unmapped 0x0C", 8'h0C, 32'h0);
        @(negedge clk);
        chk("R8 irq asserted", {31'b0, irq_out}, 32'h1);

        // Only bank A source 0 high: summary bit alone raises the request.
        src_loc = '0; src_b = '0; src_a = 32'h1;
        rd("R5 summary alone", 8'h00, 32'h0000_0100);
        @(negedge clk);
        chk("R8 irq from summary", {31'b0, irq_out}, 32'h1);
        src_a = '0;
        #1;
        chk("R8 irq lags one cycle", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        chk("R8 irq cleared", {31'b0, irq_out}, 32'h0);

        src_a = 32'h80;
        rd("R4 masked fast source", 8'h00, 32'h0);
        src_a = 32'h200;
        rd("R6 A9 bit 11 no summary", 8'h00, 32'h0000_0800);
        src_a = '0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule